// File: doc/BRIEF.md
# Phase-0 SPI Slave with Gap-Qualified Transmit Reload

This block is a byte-wide serial slave for a four-wire SPI bus that supports clock phase 0 only. The bus pins (serial clock, master-out data and an active-low select) are brought into the system clock domain through two-flop synchronisers. All bus events are then detected as transitions seen on the system clock. The system clock must run at least eight times faster than the serial clock. Software selects the idle level of the serial clock and whether bytes travel least or most significant bit first. The same bit order applies in both directions.

Each transfer is eight bits. The bit the slave sends first appears on the output pin as soon as select is seen low, before any clock edge. Incoming data is captured on the edges that leave the idle level. Outgoing data moves on the edges that return to it. A completed byte is presented on a parallel output with a single-cycle strobe.

The byte sent at the start of a transfer depends on how long select was released beforehand. If select stayed high for at least a programmable number of system clocks, the slave sends its transmit register. If select stayed low, or the gap was shorter than that, it sends back the byte it last received. If select is released part way through a byte, the partial byte is discarded and the bit position restarts.

Top module: `spi_p0_slave`

## Requirements
- R1: Master-out data is captured on the leading clock edges, i.e. the first, third, … fifteenth transitions after select asserts. A full byte appears unaltered on `rx_data`.
- R2: The first outgoing bit is valid on `miso_o` before the first clock edge of a transfer. Later bits change only on trailing edges (the second, fourth, … transitions).
- R3: `cpol`=0 means the clock idles low and leading edges rise. `cpol`=1 means it idles high and leading edges fall. Both settings transfer bytes identically.
- R4: `lsbfe`=0 sends and receives bit 7 first. `lsbfe`=1 sends and receives bit 0 first.
- R5: While select stays low between two bytes, the second byte sent is the byte just received.
- R6: The transmit register (written by `tx_wr` with `tx_data`) is sent only if select was high for at least `gap_min` system clocks before asserting. A shorter gap sends the last received byte.
- R7: After the sixteenth edge of a byte, `rx_data` takes the received byte and `rx_done` is high for exactly one clock.
- R8: While select is high, `miso_o` is 0. `miso_oe_o` is 0 unless the parameter `DRIVE_IDLE_LOW` is 1; it is 1 during a transfer.
- R9: Releasing select mid-byte raises no `rx_done` and discards the partial bits. The next full byte is received correctly.
- R10: After reset, `rx_data` is 0, `rx_done` is 0, `miso_o` is 0, and the first transfer sends the transmit register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sck_i | input | 1 | Serial clock from the master |
| mosi_i | input | 1 | Serial data from the master |
| ss_n_i | input | 1 | Active-low slave select |
| miso_o | output | 1 | Serial data to the master |
| miso_oe_o | output | 1 | Output enable for the MISO pad |
| cpol | input | 1 | Serial clock idle level |
| lsbfe | input | 1 | 1 = least significant bit first |
| gap_min | input | GAP_W | Minimum select-high clocks to reload the transmit register |
| tx_wr | input | 1 | Write strobe for the transmit register |
| tx_data | input | DATA_W | Transmit register write data |
| rx_data | output | DATA_W | Last complete received byte |
| rx_done | output | 1 | One-cycle strobe when a byte completes |

## Verification
Any pin change reaches the design's registers three system clocks later: two synchroniser stages plus the register that acts on the detected edge. Consequently `miso_o` settles three clocks after select falls or after a trailing edge. `rx_data` and `rx_done` update three clocks after the sixteenth edge. The bench holds every serial clock level for eight system clocks. It samples `miso_o` just before each leading edge and checks the received byte and strobe count eight clocks after the last edge, so every sample falls well after the result is due. Its reference model counts the select-high gap on the pins and chooses the expected outgoing byte without looking into the design.

// File: rtl/spi_p0_pkg.sv
// Package: shared types for the phase-0 SPI slave.
// Assumes nothing beyond a single system clock domain.
package spi_p0_pkg;

    // Bit order selection as seen on the lsbfe input.
    typedef enum logic {
        ORDER_MSB = 1'b0,
        ORDER_LSB = 1'b1
    } bit_order_e;

    // Serial clock events detected in the system clock domain.
    typedef struct packed {
        logic lead;   // transition away from the idle level (sample)
        logic trail;  // transition back to the idle level (shift)
    } sck_evt_t;

endpackage

// File: rtl/spi_p0_sync.sv
// Module: multi-bit, multi-stage synchroniser for asynchronous bus pins.
// Assumes each bit is independent; reset value is given per bit.
module spi_p0_sync #(
    parameter int          W       = 3,
    parameter int          STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [STAGES-1:0][W-1:0] stg;

    // Shift the pin values through the synchroniser chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) stg[s] <= RST_VAL;
        end else begin
            stg[0] <= d;
            for (int s = 1; s < STAGES; s++) stg[s] <= stg[s-1];
        end
    end

    assign q = stg[STAGES-1];

endmodule

// File: rtl/spi_p0_gap.sv
// Module: counts system clocks with select released, saturating.
// Assumes the count is sampled in the cycle select is first seen low.
// After reset the count starts saturated so the first transfer reloads.
module spi_p0_gap #(
    parameter int GAP_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ss_hi,
    input  logic [GAP_W-1:0] gap_min,
    output logic             gap_ok
);

    localparam logic [GAP_W-1:0] CNT_MAX = '1;

    logic [GAP_W-1:0] cnt;

    // Count idle clocks while select is high, clear while it is low.
    always_ff @(posedge clk) begin
        if (!rst_n)              cnt <= CNT_MAX;
        else if (!ss_hi)         cnt <= '0;
        else if (cnt != CNT_MAX) cnt <= cnt + 1'b1;
    end

    assign gap_ok = (cnt >= gap_min);

    // R6: the idle count never falls while select stays released.
    a_r6_gap_monotonic: assert property (@(posedge clk) disable iff (!rst_n)
        ss_hi |=> (!ss_hi || cnt >= $past(cnt)));

endmodule

// File: rtl/spi_p0_shifter.sv
// Module: phase-0 transmit/receive shift datapath.
// Assumes clock events arrive as single-cycle pulses, select is synchronised,
// and lsbfe is not changed during a transfer.
module spi_p0_shifter
    import spi_p0_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              active,
    input  logic              ss_fall,
    input  sck_evt_t          evt,
    input  logic              mosi,
    input  bit_order_e        order,
    input  logic              gap_ok,
    input  logic [DATA_W-1:0] tx_reg,
    output logic              miso_bit,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_done
);

    localparam int               CNT_W = $clog2(DATA_W + 1);
    localparam logic [CNT_W-1:0] FULL  = CNT_W'(DATA_W);

    logic [DATA_W-1:0] sh;
    logic [DATA_W-1:0] rx_sh;
    logic [CNT_W-1:0]  smp_cnt;
    logic [DATA_W-1:0] sh_next;
    logic [DATA_W-1:0] rx_next;

    // Next shift values for the selected bit order.
    always_comb begin
        if (order == ORDER_LSB) begin
            sh_next = sh >> 1;
            rx_next = {mosi, rx_sh[DATA_W-1:1]};
        end else begin
            sh_next = sh << 1;
            rx_next = {rx_sh[DATA_W-2:0], mosi};
        end
    end

    // Load, sample, shift and complete bytes on serial clock events.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh      <= '0;
            rx_sh   <= '0;
            smp_cnt <= '0;
            rx_data <= '0;
            rx_done <= 1'b0;
        end else begin
            rx_done <= 1'b0;
            if (!active) begin
                smp_cnt <= '0;
            end else if (ss_fall) begin
                sh      <= gap_ok ? tx_reg : rx_data;
                smp_cnt <= '0;
            end else if (evt.lead && smp_cnt != FULL) begin
                rx_sh   <= rx_next;
                smp_cnt <= smp_cnt + 1'b1;
            end else if (evt.trail) begin
                if (smp_cnt == FULL) begin
                    rx_data <= rx_sh;
                    rx_done <= 1'b1;
                    sh      <= rx_sh;
                    smp_cnt <= '0;
                end else if (smp_cnt != '0) begin
                    sh <= sh_next;
                end
            end
        end
    end

    assign miso_bit = (order == ORDER_LSB) ? sh[0] : sh[DATA_W-1];

    // R1: no more samples are taken than a byte holds.
    a_r1_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        smp_cnt <= FULL);

    // R7: the completion strobe lasts one clock.
    a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rx_done |=> !rx_done);

    // R5: the byte just completed is what will be shifted out next.
    a_r5_echo_loaded: assert property (@(posedge clk) disable iff (!rst_n)
        rx_done |-> (sh == rx_data));

    // R2: outgoing bit only moves on a trailing edge or a new select.
    a_r2_hold_between: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !evt.trail && !ss_fall) |=>
            (!active || order != $past(order) || $stable(miso_bit)));

endmodule

// File: rtl/spi_p0_slave.sv
// Module: top of the phase-0 SPI slave.
// Synchronises the bus pins, detects clock and select edges, tracks the
// select-high gap and drives the shift datapath.
// Assumes the system clock is at least 8x the serial clock and that the
// master honours lead, trail and idle times of a few system clocks.
module spi_p0_slave
    import spi_p0_pkg::*;
#(
    parameter int DATA_W         = 8,
    parameter int GAP_W          = 8,
    parameter bit DRIVE_IDLE_LOW = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sck_i,
    input  logic              mosi_i,
    input  logic              ss_n_i,
    output logic              miso_o,
    output logic              miso_oe_o,
    input  logic              cpol,
    input  logic              lsbfe,
    input  logic [GAP_W-1:0]  gap_min,
    input  logic              tx_wr,
    input  logic [DATA_W-1:0] tx_data,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_done
);

    localparam int          PIN_W   = 3;
    localparam logic [PIN_W-1:0] PIN_RST = 3'b100; // {ss, sck, mosi}

    logic [PIN_W-1:0]  pins_s;
    logic              s_ss, s_sck, s_mosi;
    logic              sck_q, ss_q;
    logic              active, ss_fall, gap_ok, miso_bit;
    logic [DATA_W-1:0] tx_reg;
    sck_evt_t          evt;

    spi_p0_sync #(.W(PIN_W), .STAGES(2), .RST_VAL(PIN_RST)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({ss_n_i, sck_i, mosi_i}),
        .q     (pins_s)
    );

    assign {s_ss, s_sck, s_mosi} = pins_s;

    // Remember the previous synchronised clock and select levels.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sck_q <= 1'b0;
            ss_q  <= 1'b1;
        end else begin
            sck_q <= s_sck;
            ss_q  <= s_ss;
        end
    end

    // Classify clock transitions against the configured idle level.
    always_comb begin
        evt.lead  = (s_sck != sck_q) && (s_sck != cpol);
        evt.trail = (s_sck != sck_q) && (s_sck == cpol);
    end

    assign active  = !s_ss;
    assign ss_fall = !s_ss && ss_q;

    // Hold the transmit register written from the parallel side.
    always_ff @(posedge clk) begin
        if (!rst_n)     tx_reg <= '0;
        else if (tx_wr) tx_reg <= tx_data;
    end

    spi_p0_gap #(.GAP_W(GAP_W)) u_gap (
        .clk     (clk),
        .rst_n   (rst_n),
        .ss_hi   (s_ss),
        .gap_min (gap_min),
        .gap_ok  (gap_ok)
    );

    spi_p0_shifter #(.DATA_W(DATA_W)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .active   (active),
        .ss_fall  (ss_fall),
        .evt      (evt),
        .mosi     (s_mosi),
        .order    (bit_order_e'(lsbfe)),
        .gap_ok   (gap_ok),
        .tx_reg   (tx_reg),
        .miso_bit (miso_bit),
        .rx_data  (rx_data),
        .rx_done  (rx_done)
    );

    assign miso_o = active & miso_bit;

    // Pick the pad behaviour while select is released.
    generate
        if (DRIVE_IDLE_LOW) begin : g_drive_low
            assign miso_oe_o = 1'b1;
        end else begin : g_float
            assign miso_oe_o = active;
        end
    endgenerate

    // R9/R7: a completion strobe only follows a cycle with select asserted.
    a_r9_done_needs_select: assert property (@(posedge clk) disable iff (!rst_n)
        rx_done |-> $past(active));

    // R8: data pin is low in the cycle after select is seen released.
    a_r8_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
        (s_ss && ss_q) |-> !miso_o);

endmodule

// File: tb/spi_p0_slave_tb.sv
// Bench for spi_p0_slave: behavioural master plus reference model.
module spi_p0_slave_tb;

    localparam int H = 8;   // system clocks per serial clock level

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sck_i = 1'b0, mosi_i = 1'b0, ss_n_i = 1'b1;
    logic       miso_o, miso_oe_o;
    logic       cpol = 1'b0, lsbfe = 1'b0;
    logic [7:0] gap_min = 8'd8;
    logic       tx_wr = 1'b0;
    logic [7:0] tx_data = '0;
    logic [7:0] rx_data;
    logic       rx_done;

    int n_chk = 0, n_bad = 0, cyc = 0;
    int done_pulses = 0, done_hi = 0;
    logic [7:0] got_q[$];
    logic       done_prev = 1'b0;
    int         hcnt = 1000;
    logic [7:0] tx_m = '0, last_m = '0, exp_byte = '0;

    spi_p0_slave u_dut (
        .clk(clk), .rst_n(rst_n), .sck_i(sck_i), .mosi_i(mosi_i),
        .ss_n_i(ss_n_i), .miso_o(miso_o), .miso_oe_o(miso_oe_o),
        .cpol(cpol), .lsbfe(lsbfe), .gap_min(gap_min), .tx_wr(tx_wr),
        .tx_data(tx_data), .rx_data(rx_data), .rx_done(rx_done)
    );

    always #10 clk = ~clk;

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    // Watchdog and reference gap counter on the pins.
    always @(posedge clk) begin
        cyc++;
        if (ss_n_i) hcnt++; else hcnt = 0;
        if (cyc > 150000) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual %0d cycles expected < 150000", cyc);
            finish_run();
        end
    end

    // Completion monitor, sampled away from the active edge.
    always @(negedge clk) begin
        if (rx_done) begin
            done_hi++;
            if (!done_prev) begin
                done_pulses++;
                got_q.push_back(rx_data);
            end
        end
        done_prev = rx_done;
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic wclk(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic bit_at(input logic [7:0] b, input int i);
        return lsbfe ? b[i] : b[7-i];
    endfunction

    task automatic write_tx(input logic [7:0] v);
        tx_data = v; tx_wr = 1'b1; wclk(1); tx_wr = 1'b0; tx_m = v;
    endtask

    // Model decides the outgoing byte from the pin-level gap.
    task automatic ss_low();
        exp_byte = (hcnt >= int'(gap_min)) ? tx_m : last_m;
        ss_n_i = 1'b0;
    endtask

    task automatic ss_high(input int n);
        ss_n_i = 1'b1; wclk(n);
    endtask

    // One transfer of nbits bit pairs; sck toggles from its idle level.
    task automatic xfer(input logic [7:0] mo, input int nbits,
                        input string tx_tag, input string rx_tag);
        int p0 = done_pulses;
        int h0 = done_hi;
        mosi_i = bit_at(mo, 0);
        wclk(H);
        for (int i = 0; i < nbits; i++) begin
            chk(miso_o == bit_at(exp_byte, i), tx_tag, miso_o, bit_at(exp_byte, i));
            sck_i = ~sck_i; wclk(H);
            sck_i = ~sck_i;
            if (i < 7) mosi_i = bit_at(mo, i + 1);
            wclk(H);
        end
        if (nbits == 8) begin
            chk(done_pulses == p0 + 1, "R7 pulse count", done_pulses - p0, 1);
            chk(done_hi == h0 + 1, "R7 strobe width", done_hi - h0, 1);
            if (got_q.size() > 0) begin
                logic [7:0] g = got_q.pop_front();
                chk(g == mo, rx_tag, g, mo);
            end
            last_m = mo; exp_byte = mo;
        end else begin
            chk(done_pulses == p0, "R9 no strobe on abort", done_pulses - p0, 0);
        end
    endtask

    initial begin
        wclk(3);
        rst_n = 1'b1;
        wclk(2);
        // R10: reset state
        chk(rx_data == 8'h00, "R10 rx_data", rx_data, 0);
        chk(rx_done == 1'b0, "R10 rx_done", rx_done, 0);
        chk(miso_o == 1'b0, "R10 miso", miso_o, 0);
        chk(miso_oe_o == 1'b0, "R8 oe idle", miso_oe_o, 0);

        // R10/R1/R2: first transfer after reset sends the transmit register
        write_tx(8'hA5);
        wclk(4);
        ss_low();
        wclk(4);
        chk(miso_oe_o == 1'b1, "R8 oe active", miso_oe_o, 1);
        xfer(8'h3C, 8, "R10 first tx byte", "R1 rx msb-first");
        // R5: select held low
        xfer(8'h96, 8, "R5 echo", "R1 rx second");
        ss_high(20);
        chk(miso_o == 1'b0, "R8 miso idle", miso_o, 0);
        chk(miso_oe_o == 1'b0, "R8 oe idle", miso_oe_o, 0);

        // R6: long gap reloads the transmit register
        write_tx(8'h5A);
        ss_low();
        xfer(8'hC3, 8, "R6 long gap tx", "R1 rx");
        // R6: short gap echoes last received
        ss_high(3);
        ss_low();
        chk(exp_byte == 8'hC3, "R6 model short gap", exp_byte, 8'hC3);
        xfer(8'h0F, 8, "R6 short gap echo", "R1 rx");
        ss_high(20);

        // R4: LSB first in both directions
        lsbfe = 1'b1;
        write_tx(8'h1E);
        wclk(4);
        ss_low();
        xfer(8'h81, 8, "R4 lsb-first tx", "R4 lsb-first rx");
        xfer(8'h34, 8, "R4 lsb-first echo", "R4 lsb-first rx2");
        ss_high(20);
        lsbfe = 1'b0;

        // R3: clock idling high
        cpol = 1'b1; sck_i = 1'b1;
        write_tx(8'h69);
        wclk(20);
        ss_low();
        xfer(8'hE7, 8, "R3 cpol1 tx", "R3 cpol1 rx");
        xfer(8'h52, 8, "R3 cpol1 echo", "R3 cpol1 rx2");
        ss_high(20);
        cpol = 1'b0; sck_i = 1'b0;
        wclk(20);

        // R9: abort mid-byte, then a clean byte
        write_tx(8'h77);
        ss_low();
        xfer(8'hFF, 3, "R9 partial tx", "R9 unused");
        ss_high(20);
        ss_low();
        xfer(8'h42, 8, "R9 tx after abort", "R9 rx after abort");
        ss_high(20);
        chk(rx_data == 8'h42, "R9 rx_data held", rx_data, 8'h42);

        finish_run();
    end

endmodule